// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block moves an 8-bit word between two buses, called A and B, in one direction at a time. Each bus has its own input, output and output-enable signals, so the block never needs tristate wires inside the chip. The pad or bus owner outside the block uses the enable flags to decide who drives each bus.

There is one storage register for each direction. The A-to-B register captures the A input on the rising edge of its own clock. The B-to-A register captures the B input on the rising edge of a second, independent clock. A select input for each direction chooses what the driven bus receives: either the live word from the opposite bus, passed straight through, or the word held in that direction's register.

An active-low output enable and a direction input choose which bus is driven, if any. Capture does not depend on these controls. A word can be stored while both outputs are off and driven out later.

Top module: `xcvr_regbus`

## Requirements
- R1: When `rst` is high at a rising edge of a register's clock, that register becomes all zeros (A-to-B register on `clk_ab`, B-to-A register on `clk_ba`).
- R2: At each rising edge of `clk_ab` with `rst` low, the A-to-B register loads `a_in`. Between edges it holds its value.
- R3: At each rising edge of `clk_ba` with `rst` low, the B-to-A register loads `b_in`. Between edges it holds its value.
- R4: When `oe_n` is 0 and `dir` is 1, `b_oe` is 1 and `a_oe` is 0. When `oe_n` is 0 and `dir` is 0, `a_oe` is 1 and `b_oe` is 0. `a_oe` and `b_oe` are never 1 at the same time.
- R5: When `oe_n` is 1, both `a_oe` and `b_oe` are 0.
- R6: When `sel_ab` is 0, `b_out` equals `a_in` with no clock in the path. When `sel_ba` is 0, `a_out` equals `b_in` with no clock in the path.
- R7: When `sel_ab` is 1, `b_out` equals the A-to-B register. When `sel_ba` is 1, `a_out` equals the B-to-A register.
- R8: Capture on either clock works whatever the values of `oe_n` and `dir`. A word captured while `oe_n` is 1 is driven on the bus selected later in stored mode.
- R9: In stored mode, the output shows the newly captured word straight after the clock edge that loads it, not the live input.
- R10: Pulsing `clk_ab` and `clk_ba` on the same edge loads both registers at once, and neither capture disturbs the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock for the A-to-B register |
| clk_ba | input | 1 | Capture clock for the B-to-A register |
| rst | input | 1 | Synchronous active-high reset, sampled by each clock |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | Direction: 1 drives B, 0 drives A |
| sel_ab | input | 1 | B output source: 0 live A, 1 stored |
| sel_ba | input | 1 | A output source: 0 live B, 1 stored |
| a_in | input | 8 | Word received from bus A |
| b_in | input | 8 | Word received from bus B |
| a_out | output | 8 | Word offered to bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_out | output | 8 | Word offered to bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
A capture into a register and a stored-mode read of that same register can fall in the same cycle. The output then has to move to the new word at once. The bench provokes this by gating each capture clock with a random enable while the selects are often in stored mode. Outputs are compared against the behavioural model just before and just after every edge, so a stale or live word at that moment is caught. Captures on both clocks at the same edge, and captures while the outputs are off, are also forced in directed steps.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic drive_a;
        logic drive_b;
    } drive_ctl_t;

    function automatic drive_ctl_t decode_drive(input logic oe_n, input logic dir);
        drive_ctl_t c;
        c.drive_b = ~oe_n & dir;
        c.drive_a = ~oe_n & ~dir;
        return c;
    endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/xcvr_src_mux.sv
module xcvr_src_mux
    import xcvr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  src_sel_e     sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (sel)
            SRC_STORED: y = stored;
            default:    y = live;
        endcase
    end
endmodule

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
    import xcvr_pkg::*;
(
    input  logic oe_n,
    input  logic dir,
    output logic a_oe,
    output logic b_oe
);
    drive_ctl_t ctl;
    always_comb begin
        ctl  = decode_drive(oe_n, dir);
        a_oe = ctl.drive_a;
        b_oe = ctl.drive_b;
    end
endmodule

// File: rtl/xcvr_regbus.sv
module xcvr_regbus
    import xcvr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         rst,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    logic [W-1:0] reg_ab;
    logic [W-1:0] reg_ba;

    xcvr_capture_reg #(.W(W)) u_reg_ab (
        .clk (clk_ab),
        .rst (rst),
        .d   (a_in),
        .q   (reg_ab)
    );

    xcvr_capture_reg #(.W(W)) u_reg_ba (
        .clk (clk_ba),
        .rst (rst),
        .d   (b_in),
        .q   (reg_ba)
    );

    xcvr_src_mux #(.W(W)) u_mux_b (
        .sel    (src_sel_e'(sel_ab)),
        .live   (a_in),
        .stored (reg_ab),
        .y      (b_out)
    );

    xcvr_src_mux #(.W(W)) u_mux_a (
        .sel    (src_sel_e'(sel_ba)),
        .live   (b_in),
        .stored (reg_ba),
        .y      (a_out)
    );

    xcvr_dir_ctrl u_dir (
        .oe_n (oe_n),
        .dir  (dir),
        .a_oe (a_oe),
        .b_oe (b_oe)
    );
endmodule

// File: rtl/xcvr_regbus_chk.sv
module xcvr_regbus_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         rst,
    input logic         oe_n,
    input logic         dir,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic [W-1:0] reg_ab,
    input logic [W-1:0] reg_ba
);
    AST_RESET_AB: assert property (@(posedge clk_ab) rst |=> reg_ab == '0); // R1
    AST_RESET_BA: assert property (@(posedge clk_ba) rst |=> reg_ba == '0); // R1
    AST_LOAD_AB: assert property (@(posedge clk_ab) disable iff (rst) !rst |=> reg_ab == $past(a_in)); // R2
    AST_LOAD_BA: assert property (@(posedge clk_ba) disable iff (rst) !rst |=> reg_ba == $past(b_in)); // R3
    AST_ONE_BUS: assert property (@(posedge clk_ab) disable iff (rst) !(a_oe && b_oe)); // R4
    AST_DIR_B: assert property (@(posedge clk_ab) disable iff (rst) (!oe_n && dir) |-> (b_oe && !a_oe)); // R4
    AST_ISOLATE: assert property (@(posedge clk_ab) disable iff (rst) oe_n |-> (!a_oe && !b_oe)); // R5
    AST_LIVE_B: assert property (@(posedge clk_ab) disable iff (rst) !sel_ab |-> b_out == a_in); // R6
    AST_LIVE_A: assert property (@(posedge clk_ba) disable iff (rst) !sel_ba |-> a_out == b_in); // R6
    AST_STORED_B: assert property (@(posedge clk_ab) disable iff (rst) sel_ab |-> b_out == reg_ab); // R7
    AST_STORED_A: assert property (@(posedge clk_ba) disable iff (rst) sel_ba |-> a_out == reg_ba); // R7
endmodule

bind xcvr_regbus xcvr_regbus_chk #(.W(W)) u_chk (
    .clk_ab (clk_ab),
    .clk_ba (clk_ba),
    .rst    (rst),
    .oe_n   (oe_n),
    .dir    (dir),
    .sel_ab (sel_ab),
    .sel_ba (sel_ba),
    .a_in   (a_in),
    .b_in   (b_in),
    .a_out  (a_out),
    .a_oe   (a_oe),
    .b_out  (b_out),
    .b_oe   (b_oe),
    .reg_ab (reg_ab),
    .reg_ba (reg_ba)
);

// File: tb/xcvr_regbus_tb.sv
module xcvr_regbus_tb;
    localparam int W = 8;

    logic clk = 1'b0;
    logic en_ab = 1'b0, en_ba = 1'b0;
    logic rst = 1'b1, oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic a_oe, b_oe;
    logic clk_ab, clk_ba;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [W-1:0] m_ab = '0, m_ba = '0;

    always #5 clk = ~clk;
    assign clk_ab = clk & en_ab;
    assign clk_ba = clk & en_ba;

    xcvr_regbus #(.W(W)) u_dut (
        .clk_ab (clk_ab), .clk_ba (clk_ba), .rst (rst),
        .oe_n (oe_n), .dir (dir), .sel_ab (sel_ab), .sel_ba (sel_ba),
        .a_in (a_in), .b_in (b_in),
        .a_out (a_out), .a_oe (a_oe), .b_out (b_out), .b_oe (b_oe)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all(input string extra);
        string tb_tag, ta_tag, oe_tag;
        tb_tag = (extra != "") ? extra : (sel_ab ? "R7" : "R6");
        ta_tag = (extra != "") ? extra : (sel_ba ? "R7" : "R6");
        oe_tag = oe_n ? "R5" : "R4";
        check(tb_tag, int'(b_out), int'(sel_ab ? m_ab : a_in));
        check(ta_tag, int'(a_out), int'(sel_ba ? m_ba : b_in));
        check(oe_tag, int'(b_oe), int'(!oe_n && dir));
        check(oe_tag, int'(a_oe), int'(!oe_n && !dir));
        check("R4", int'(a_oe && b_oe), 0);
    endtask

    // One bench cycle: inputs already set at negedge; check, clock, update model, check again
    task automatic step(input string after_tag);
        #1 compare_all("");
        @(posedge clk);
        if (en_ab) m_ab = rst ? '0 : a_in;
        if (en_ba) m_ba = rst ? '0 : b_in;
        #1 compare_all(after_tag);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        rst = 1'b1; en_ab = 1'b1; en_ba = 1'b1;
        a_in = 8'hA5; b_in = 8'h3C;
        repeat (2) step("R1");
        rst = 1'b0; en_ab = 1'b0; en_ba = 1'b0;
        sel_ab = 1'b1; sel_ba = 1'b1;
        #1;
        check("R1", int'(b_out), 0);
        check("R1", int'(a_out), 0);

        // R8: capture in isolation, then drive the stored word
        oe_n = 1'b1; a_in = 8'h5A; en_ab = 1'b1;
        step("R8");
        en_ab = 1'b0; a_in = 8'h11; oe_n = 1'b0; dir = 1'b1;
        #1;
        check("R8", int'(b_out), 8'h5A);
        check("R8", int'(b_oe), 1);
        check("R2", int'(b_out), 8'h5A);

        // R3 and R8: B capture with A driven direction, stored out on A
        oe_n = 1'b1; b_in = 8'hC3; en_ba = 1'b1;
        step("R3");
        en_ba = 1'b0; b_in = 8'h00; oe_n = 1'b0; dir = 1'b0;
        #1;
        check("R3", int'(a_out), 8'hC3);
        check("R8", int'(a_oe), 1);

        // R10: both clocks on the same edge
        a_in = 8'h77; b_in = 8'h99; en_ab = 1'b1; en_ba = 1'b1;
        step("R10");
        en_ab = 1'b0; en_ba = 1'b0; a_in = 8'h01; b_in = 8'h02;
        #1;
        check("R10", int'(b_out), 8'h77);
        check("R10", int'(a_out), 8'h99);

        // R9: stored output follows the fresh capture right after the edge
        a_in = 8'hE4; en_ab = 1'b1;
        step("R9");
        en_ab = 1'b0;

        // R6: live pass-through
        sel_ab = 1'b0; sel_ba = 1'b0; a_in = 8'h3F; b_in = 8'hF3;
        #1;
        check("R6", int'(b_out), 8'h3F);
        check("R6", int'(a_out), 8'hF3);

        // Random traffic: R1..R10 cross cases
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            rst    = ($urandom % 40) == 0;
            oe_n   = $urandom;
            dir    = $urandom;
            sel_ab = $urandom;
            sel_ba = $urandom;
            en_ab  = $urandom;
            en_ba  = $urandom;
            a_in   = $urandom;
            b_in   = $urandom;
            step((sel_ab && en_ab && !rst) ? "R9" : (rst ? "R1" : ""));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule